// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block lets a processor operate a raw 8-bit NAND flash device through one 32-bit register on a small synchronous slave bus. Each register write chooses a flash cycle type with a 3-bit code, sets or clears the chip enable, and carries a data byte. The bridge then drives the command-latch and address-latch levels, the active-low chip enable, and timed write or read strobes. It drives the 8-bit flash I/O bus only while a write-type cycle is in progress.

The cycle type and the enable are held between accesses. Software can therefore stream command, address or data bytes with a run of plain writes. When the read type is armed, each register read pulses the read strobe once and returns the byte the flash presents. Register reads also report the flash ready/busy pin. Command sequencing, ECC and DMA are left to software.

Setup, strobe-low and hold times are parameters counted in clock cycles. A transfer is complete in the single cycle where `bus_ready` is high. The master holds `bus_valid` and its request fields steady until that cycle, and drops `bus_valid` before the following clock edge.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, `nf_ce_n`, `nf_we_n` and `nf_re_n` are high, `nf_cle` and `nf_ale` are low, `bus_ready` is low, and the captured byte is 0x00.
- R2: A write with type code 0 (bits 30:28) gives exactly one `nf_we_n` low pulse with `nf_cle` high and `nf_ale` low. During that cycle the I/O bus carries write-data bits 23:16.
- R3: A write with type code 1 gives one `nf_we_n` pulse with `nf_ale` high and `nf_cle` low, and drives bits 23:16 on the I/O bus.
- R4: A write with type code 3 gives one `nf_we_n` pulse with both latch levels low, and drives bits 23:16 on the I/O bus.
- R5: `nf_ce_n` is low exactly while the most recent register write had bit 31 set. This holds for every type code.
- R6: A write with type code 2 produces no strobe. While that type is held, each register read gives one `nf_re_n` low pulse and returns in read bits 23:16 the I/O bus value sampled on the last clock of the low phase.
- R7: Type codes 4 to 7 produce no strobe, leave both latch levels low and still update the enable.
- R8: Read bit 15 is 1 while `nf_rb_n` is low (busy) and 0 while it is high. All read bits other than 23:16 and 15 are 0.
- R9: A register read while the held type is not code 2 gives no `nf_re_n` pulse and returns the last captured byte.
- R10: `bus_ready` is high for exactly one cycle. It comes SETUP_CYC+LOW_CYC+HOLD_CYC+1 cycles after the accepting edge for a strobed access, and 1 cycle after it otherwise. The strobe stays low for LOW_CYC cycles.
- R11: The bridge drives the I/O bus only during the setup, low and hold phases of a write-type strobe. At all other times the bus is released.
- R12: Consecutive writes with the same type code each produce their own strobe with the same latch levels. The held type never changes while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, held until the ready cycle |
| bus_write | input | 1 | 1 = register write, 0 = register read |
| bus_wdata | input | 32 | Write word: bit 31 enable, 30:28 type code, 23:16 byte |
| bus_rdata | output | 32 | Read word: 23:16 captured byte, 15 busy; valid while bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb_n | input | 1 | Flash ready/busy, low while busy |
| nf_io | inout | 8 | Flash data bus |

## Verification
The hardest case to reach is a register read that hits the flash. Only the sticky type code 2 allows it, and two reads in a row must each capture a different byte that the flash presents only while the read strobe is low. The bench arms code 2 and changes the modelled flash byte between reads. It then switches to an idle code and reads again to show that no strobe is issued and the last byte is kept. The busy bit is exercised by lowering the ready/busy line a few cycles before a read that does not touch the flash.

// File: rtl/nand_bridge_pkg.sv
// Package: shared encodings and register field positions for the NAND bridge.
// Assumes: one 32-bit register and type codes 0..3 as active cycle types.
package nand_bridge_pkg;

    typedef enum logic [2:0] {
        CYC_CMD  = 3'd0,
        CYC_ADDR = 3'd1,
        CYC_RD   = 3'd2,
        CYC_WR   = 3'd3,
        CYC_IDLE = 3'd4
    } cyc_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HOLD,
        PH_DONE
    } phase_e;

    localparam int EN_BIT   = 31;
    localparam int CODE_HI  = 30;
    localparam int CODE_LO  = 28;
    localparam int BYTE_HI  = 23;
    localparam int BYTE_LO  = 16;
    localparam int BUSY_BIT = 15;

    // Map a raw 3-bit code onto a cycle type; codes 4..7 collapse to idle.
    function automatic cyc_e decode_code(input logic [2:0] code);
        if (code > 3'd3) return CYC_IDLE;
        return cyc_e'(code);
    endfunction

    // True for cycle types that issue a write strobe.
    function automatic logic is_write_type(input cyc_e c);
        return (c == CYC_CMD) || (c == CYC_ADDR) || (c == CYC_WR);
    endfunction

endpackage

// File: rtl/nand_mode_reg.sv
// Module: holds the sticky cycle type, chip enable and outgoing byte.
// Assumes: load is a single-cycle pulse that comes only at write acceptance.
module nand_mode_reg
    import nand_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] wdata,
    output cyc_e        mode,
    output logic        enable,
    output logic [7:0]  out_byte
);

    // Latch the fields of an accepted write; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= CYC_IDLE;
            enable   <= 1'b0;
            out_byte <= 8'h00;
        end else if (load) begin
            mode     <= decode_code(wdata[CODE_HI:CODE_LO]);
            enable   <= wdata[EN_BIT];
            out_byte <= wdata[BYTE_HI:BYTE_LO];
        end
    end

endmodule

// File: rtl/nand_strobe_seq.sv
// Module: phase sequencer for one flash access (setup, low, hold, done).
// Assumes: every phase length is at least one cycle; start only comes in PH_IDLE.
module nand_strobe_seq
    import nand_bridge_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned LOW_CYC   = 3,
    parameter int unsigned HOLD_CYC  = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   do_strobe,
    output phase_e phase,
    output logic   last_low
);

    localparam int unsigned MAXT_A = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
    localparam int unsigned MAXT   = (MAXT_A > HOLD_CYC) ? MAXT_A : HOLD_CYC;
    localparam int          CW     = $clog2(MAXT) + 1;

    logic [CW-1:0] cnt;

    assign last_low = (phase == PH_LOW) && (cnt == '0);

    // Step through the phases, reloading the cycle counter on each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    if (do_strobe) begin
                        phase <= PH_SETUP;
                        cnt   <= CW'(SETUP_CYC - 1);
                    end else begin
                        phase <= PH_DONE;
                    end
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_LOW;
                    cnt   <= CW'(LOW_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_LOW: if (cnt == '0) begin
                    phase <= PH_HOLD;
                    cnt   <= CW'(HOLD_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_HOLD: if (cnt == '0) begin
                    phase <= PH_DONE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // The done phase lasts one cycle and is always followed by idle.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE));

endmodule

// File: rtl/nand_reg_bridge.sv
// Module: top of the register-mapped NAND flash bridge.
// Assumes: the master holds its request until bus_ready and drops it in that cycle;
//          nf_rb_n is synchronous to clk or slow enough for a single sampling flop.
module nand_reg_bridge
    import nand_bridge_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned LOW_CYC   = 3,
    parameter int unsigned HOLD_CYC  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_ce_n,
    output logic        nf_we_n,
    output logic        nf_re_n,
    input  logic        nf_rb_n,
    inout  wire  [7:0]  nf_io
);

    cyc_e       mode;
    logic       enable;
    logic [7:0] out_byte;
    phase_e     phase;
    logic       last_low;
    logic       accept;
    logic       do_strobe;
    logic       op_wr;
    logic       io_oe;
    logic [7:0] data_q;
    logic       busy_q;

    assign accept    = bus_valid && (phase == PH_IDLE);
    assign do_strobe = bus_write ? is_write_type(decode_code(bus_wdata[CODE_HI:CODE_LO]))
                                 : (mode == CYC_RD);

    nand_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && bus_write),
        .wdata    (bus_wdata),
        .mode     (mode),
        .enable   (enable),
        .out_byte (out_byte)
    );

    nand_strobe_seq #(
        .SETUP_CYC (SETUP_CYC),
        .LOW_CYC   (LOW_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .do_strobe (do_strobe),
        .phase     (phase),
        .last_low  (last_low)
    );

    // Remember whether the access in progress is a write or a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      op_wr <= 1'b0;
        else if (accept) op_wr <= bus_write;
    end

    // Capture the flash byte on the last low cycle of a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= 8'h00;
        else if (last_low && !op_wr) data_q <= nf_io;
    end

    // Sample the ready/busy pin once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= ~nf_rb_n;
    end

    // Decode the flash pins from the held type and the current phase.
    always_comb begin
        nf_cle  = (mode == CYC_CMD);
        nf_ale  = (mode == CYC_ADDR);
        nf_ce_n = ~enable;
        nf_we_n = ~((phase == PH_LOW) && op_wr);
        nf_re_n = ~((phase == PH_LOW) && !op_wr);
        io_oe   = op_wr && ((phase == PH_SETUP) || (phase == PH_LOW) || (phase == PH_HOLD));
    end

    assign nf_io     = io_oe ? out_byte : 8'hzz;
    assign bus_ready = (phase == PH_DONE);
    assign bus_rdata = {8'h00, data_q, busy_q, 15'h0000};

    // A write strobe only appears while a write-type cycle is held.
    assert_we_in_write_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> is_write_type(mode));

    // A read strobe only appears while the read type is held.
    assert_re_in_read_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> (mode == CYC_RD));

    // Completion is a single-cycle pulse.
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // The held type cannot change while an access is in progress.
    assert_mode_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(mode));

    // The bridge never drives the bus during a read strobe.
    assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !io_oe);

endmodule

// File: tb/nand_reg_bridge_test.sv
`timescale 1ns/1ps
// Bench: a behavioural per-cycle model of the strobe waveform, compared on every clock,
// plus directed transfers that check returned data and completion latency.
module nand_reg_bridge_test;

    localparam int TS = 2;
    localparam int TL = 3;
    localparam int TH = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n;
    logic        nf_rb_n = 1'b1;
    wire  [7:0]  nf_io;
    logic [7:0]  flash_byte = 8'h00;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign nf_io = (!nf_re_n) ? flash_byte : 8'hzz;

    nand_reg_bridge #(.SETUP_CYC(TS), .LOW_CYC(TL), .HOLD_CYC(TH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_rb_n(nf_rb_n), .nf_io(nf_io)
    );

    // Reference model state.
    int m_mode = 4;
    bit m_en = 1'b0;
    bit q_we[$];
    bit q_re[$];
    bit q_rdy[$];
    int q_io[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model: on an accepting edge, queue the expected pins for each following cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_we.delete(); q_re.delete(); q_rdy.delete(); q_io.delete();
            m_mode = 4; m_en = 1'b0;
        end else if (bus_valid && q_rdy.size() == 0) begin
            bit strobe;
            bit wr;
            int byt;
            wr = bus_write;
            byt = bus_wdata[23:16];
            if (wr) begin
                m_mode = (bus_wdata[30:28] > 3) ? 4 : int'(bus_wdata[30:28]);
                m_en = bus_wdata[31];
                strobe = (m_mode == 0 || m_mode == 1 || m_mode == 3);
            end else begin
                strobe = (m_mode == 2);
            end
            if (strobe) begin
                for (int i = 0; i < TS + TL + TH; i++) begin
                    bit low;
                    low = (i >= TS) && (i < TS + TL);
                    q_we.push_back(!(low && wr));
                    q_re.push_back(!(low && !wr));
                    q_rdy.push_back(1'b0);
                    q_io.push_back(wr ? byt : -1);
                end
            end
            q_we.push_back(1'b1); q_re.push_back(1'b1); q_rdy.push_back(1'b1); q_io.push_back(-1);
        end
    end

    // Compare the pins with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ew, er, ey;
            int eio;
            ew = 1'b1; er = 1'b1; ey = 1'b0; eio = -1;
            if (q_rdy.size() != 0) begin
                ew = q_we.pop_front(); er = q_re.pop_front();
                ey = q_rdy.pop_front(); eio = q_io.pop_front();
            end
            check(nf_we_n == ew, "R2/R3/R4/R10 we strobe", nf_we_n, ew);
            check(nf_re_n == er, "R6/R9/R10 re strobe", nf_re_n, er);
            check(bus_ready == ey, "R10 ready timing", bus_ready, ey);
            check(nf_cle == (m_mode == 0), "R2/R7 cle level", nf_cle, m_mode == 0);
            check(nf_ale == (m_mode == 1), "R3/R7 ale level", nf_ale, m_mode == 1);
            check(nf_ce_n == !m_en, "R5 chip enable", nf_ce_n, !m_en);
            if (eio >= 0) check(nf_io == eio[7:0], "R11 io drive", nf_io, eio);
        end
    end

    // One register access; returns the read word and the cycles to completion.
    task automatic xfer(input bit wr, input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_wdata = wd;
        cyc = 0; rd = '0;
        while (cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (bus_ready) begin
                rd = bus_rdata;
                bus_valid = 1'b0;
                break;
            end
        end
    endtask

    function automatic logic [31:0] word(input bit en, input int code, input logic [7:0] b);
        return {en, 3'(code), 4'h0, b, 16'h0000};
    endfunction

    localparam int STROBED = TS + TL + TH + 1;

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset levels
        check(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes high", {nf_ce_n, nf_we_n, nf_re_n}, 7);
        check(!nf_cle && !nf_ale && !bus_ready, "R1 latches low", {nf_cle, nf_ale, bus_ready}, 0);
        xfer(1'b0, '0, rd, cyc);
        check(rd == 32'h0, "R1 captured byte zero", rd, 0);
        check(cyc == 1, "R10 unstrobed latency", cyc, 1);

        // R2: command latch
        xfer(1'b1, word(1, 0, 8'h70), rd, cyc);
        check(cyc == STROBED, "R2 command latency", cyc, STROBED);
        check(nf_cle && !nf_ale && !nf_ce_n, "R2 R5 command levels", {nf_cle, nf_ale, nf_ce_n}, 4);

        // R3 R12: two address bytes stream with the same levels
        xfer(1'b1, word(1, 1, 8'h12), rd, cyc);
        check(cyc == STROBED, "R3 address latency", cyc, STROBED);
        xfer(1'b1, word(1, 1, 8'h34), rd, cyc);
        check(cyc == STROBED && nf_ale && !nf_cle, "R12 streamed address", cyc, STROBED);

        // R4 R12: data writes
        for (int i = 0; i < 3; i++) begin
            xfer(1'b1, word(1, 3, 8'hA0 + 8'(i)), rd, cyc);
            check(cyc == STROBED && !nf_ale && !nf_cle, "R4 data write", cyc, STROBED);
        end

        // R8 R9: busy bit, no flash read outside read type
        nf_rb_n = 1'b0;
        repeat (3) @(negedge clk);
        xfer(1'b0, '0, rd, cyc);
        check(rd == 32'h0000_8000, "R8 busy set", rd, 32'h8000);
        check(cyc == 1, "R9 no read strobe", cyc, 1);
        nf_rb_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: arm read, two reads fetch two bytes
        xfer(1'b1, word(1, 2, 8'hFF), rd, cyc);
        check(cyc == 1, "R6 arm without strobe", cyc, 1);
        flash_byte = 8'hA5;
        xfer(1'b0, '0, rd, cyc);
        check(rd == 32'h00A5_0000, "R6 first read byte", rd, 32'h00A50000);
        check(cyc == STROBED, "R6 read latency", cyc, STROBED);
        flash_byte = 8'h3C;
        xfer(1'b0, '0, rd, cyc);
        check(rd == 32'h003C_0000, "R6 second read byte", rd, 32'h003C0000);

        // R7 R5: idle code with enable off, then R9 read keeps last byte
        xfer(1'b1, word(0, 5, 8'h55), rd, cyc);
        check(cyc == 1 && nf_ce_n && !nf_cle && !nf_ale, "R7 idle code 5", cyc, 1);
        flash_byte = 8'h99;
        xfer(1'b0, '0, rd, cyc);
        check(rd == 32'h003C_0000 && cyc == 1, "R9 keep last byte", rd, 32'h003C0000);
        xfer(1'b1, word(1, 7, 8'h00), rd, cyc);
        check(cyc == 1 && !nf_ce_n, "R7 idle code 7 enables", nf_ce_n, 0);

        // R11: a write after reads still drives its byte (model checks each cycle)
        xfer(1'b1, word(1, 3, 8'h5A), rd, cyc);
        check(cyc == STROBED, "R11 write after read", cyc, STROBED);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule